// File: doc/BRIEF.md
# Bridge Positive Address Decoder

This block decides which bus cycles a bus bridge claims. It looks at every I/O address and every memory address offered to it. An I/O cycle is claimed positively when it hits one of two fixed legacy port groups and that group is enabled. The two groups are an interrupt-controller group and a disk-controller group, and the disk-controller group can be set to a primary or a secondary channel. A memory cycle is forwarded to the other bus when it hits one of two programmable BIOS regions. The first region is the low BIOS area just below 1 MB. The second is the 64 KB alias at the top of the memory space, and it is forwarded only when it falls inside a programmed memory hole or at or above the programmed top of main memory.

A small register port holds the state that drives these decisions. It has an 8-bit control register and three boundary registers: hole bottom, hole top and top of memory. The boundary registers count in 64 KB pages. The claim, fallback and forward outputs are combinational from the addresses and the register state. A mode output tells the surrounding logic which fallback style to use for memory cycles that nobody claims.

Top module: `bridge_pos_decoder`

## Requirements
- R1: After reset, all four registers read 0, `neg_mode` is 0, no I/O address is claimed and no memory address is forwarded.
- R2: With control bit 1 (interrupt group enable) set, exactly the I/O addresses 0x020, 0x021, 0x0A0 and 0x0A1 are claimed by this group. Decode uses all 16 address bits, so an address such as 0x1020 is not claimed.
- R3: With control bit 2 (disk group enable) set and control bit 3 at 0, the group claims 0x1F0 to 0x1F7 and 0x3F6 to 0x3F7, and nothing else.
- R4: With control bits 2 and 3 both set, the disk group claims 0x170 to 0x177 and 0x376 to 0x377 instead of the primary set.
- R5: A group whose enable bit is 0 claims nothing. Whenever `io_req` is high and `io_claim` is low, `io_fallback` is high, so an unclaimed address stays reachable through the fallback path.
- R6: `neg_mode` equals control bit 0, where 1 selects negative fallback and 0 selects subtractive fallback.
- R7: With control bit 4 set, memory addresses 0x0E0000 to 0x0FFFFF are forwarded, and 0x0DFFFF and 0x100000 are not forwarded.
- R8: With control bit 5 set, an address from 0xFF0000 to 0xFFFFFF is forwarded only if its page (address bits 23:16) lies inside the hole or is at or above the top-of-memory value.
- R9: The hole is the set of pages p with bottom ≤ p < top. The hole is empty whenever top ≤ bottom.
- R10: Control bits 7:6 and any boundary-register bits above bit 8 are reserved. They always read as 0. No register changes while `reg_we` is low.
- R11: While `io_req` is low, `io_claim` and `io_fallback` are both 0. While `mem_req` is low, `mem_fwd` is 0.
- R12: Register index 0 selects control, 1 selects hole bottom, 2 selects hole top and 3 selects top of memory. Each boundary register holds 9 bits and reads back what was written to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset for the registers |
| reg_we | input | 1 | Write strobe for the register selected by `reg_idx` |
| reg_idx | input | 2 | Register select: 0 control, 1 hole bottom, 2 hole top, 3 top of memory |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| io_req | input | 1 | An I/O cycle is being offered |
| io_addr | input | 16 | I/O address |
| io_claim | output | 1 | The I/O cycle is claimed by positive decode |
| io_fallback | output | 1 | The I/O cycle is offered but not claimed, and is left to the fallback path |
| mem_req | input | 1 | A memory cycle is being offered |
| mem_addr | input | 24 | Memory address |
| mem_fwd | output | 1 | The memory cycle is forwarded to the other bus |
| neg_mode | output | 1 | Fallback style: 1 negative, 0 subtractive |

## Verification
The bench builds the block with its default parameters: 16-bit I/O addresses, 24-bit memory addresses and a 64 KB page size. With these values the real legacy port addresses and both BIOS regions sit at their true locations. The boundary sweeps therefore probe the exact edges, and the I/O aliases at 0x1020 and 0x11F0 show that decode uses all 16 address bits. The 9-bit boundary registers allow a top of memory of 0x100 (16 MB). This is what lets the high alias fail the top-of-memory test, so the hole condition can be seen to act on its own.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  // Control register layout, LSB first: mode, group enables, disk select, BIOS enables.
  typedef struct packed {
    logic [1:0] rsvd;
    logic       hi_alias_en;
    logic       lo_bios_en;
    logic       disk_sec;
    logic       disk_en;
    logic       intc_en;
    logic       neg_mode;
  } dec_ctrl_t;

  typedef enum logic [1:0] {
    RIDX_CTRL = 2'd0,
    RIDX_HBOT = 2'd1,
    RIDX_HTOP = 2'd2,
    RIDX_TOM  = 2'd3
  } reg_idx_e;

  localparam int          CTRL_W     = 8;
  localparam logic [7:0]  CTRL_WMASK = 8'h3F;

endpackage

// File: rtl/bpd_regs.sv
module bpd_regs
  import bpd_pkg::*;
#(
  parameter int REG_DW = 16,
  parameter int BND_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [REG_DW-1:0] wdata,
  output dec_ctrl_t         ctrl,
  output logic [BND_W-1:0]  hole_bot,
  output logic [BND_W-1:0]  hole_top,
  output logic [BND_W-1:0]  tom,
  output logic [REG_DW-1:0] rdata
);

  localparam int CPAD = REG_DW - CTRL_W;
  localparam int BPAD = REG_DW - BND_W;

  reg_idx_e sel;
  assign sel = reg_idx_e'(idx);

  logic wr_ctrl, wr_hbot, wr_htop, wr_tom;
  assign wr_ctrl = we && (sel == RIDX_CTRL);
  assign wr_hbot = we && (sel == RIDX_HBOT);
  assign wr_htop = we && (sel == RIDX_HTOP);
  assign wr_tom  = we && (sel == RIDX_TOM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      hole_bot <= '0;
      hole_top <= '0;
      tom      <= '0;
    end else begin
      if (wr_ctrl) ctrl     <= dec_ctrl_t'(wdata[CTRL_W-1:0] & CTRL_WMASK);
      if (wr_hbot) hole_bot <= wdata[BND_W-1:0];
      if (wr_htop) hole_top <= wdata[BND_W-1:0];
      if (wr_tom)  tom      <= wdata[BND_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      RIDX_CTRL: rdata = {{CPAD{1'b0}}, ctrl};
      RIDX_HBOT: rdata = {{BPAD{1'b0}}, hole_bot};
      RIDX_HTOP: rdata = {{BPAD{1'b0}}, hole_top};
      default:   rdata = {{BPAD{1'b0}}, tom};
    endcase
  end

endmodule

// File: rtl/bpd_io_decode.sv
module bpd_io_decode #(
  parameter int IO_AW = 16
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             intc_en,
  input  logic             disk_en,
  input  logic             disk_sec,
  output logic             intc_hit,
  output logic             disk_hit,
  output logic             claim
);

  localparam int NCH = 2;  // 0 primary, 1 secondary

  function automatic logic in_win(input logic [IO_AW-1:0] a,
                                  input logic [IO_AW-1:0] lo,
                                  input logic [IO_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  localparam logic [IO_AW-1:0] INTC_A_LO = IO_AW'('h020);
  localparam logic [IO_AW-1:0] INTC_A_HI = IO_AW'('h021);
  localparam logic [IO_AW-1:0] INTC_B_LO = IO_AW'('h0A0);
  localparam logic [IO_AW-1:0] INTC_B_HI = IO_AW'('h0A1);

  logic [NCH-1:0] ch_hit;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam logic [IO_AW-1:0] CMD_LO = (c == 0) ? IO_AW'('h1F0) : IO_AW'('h170);
    localparam logic [IO_AW-1:0] CMD_HI = (c == 0) ? IO_AW'('h1F7) : IO_AW'('h177);
    localparam logic [IO_AW-1:0] AUX_LO = (c == 0) ? IO_AW'('h3F6) : IO_AW'('h376);
    localparam logic [IO_AW-1:0] AUX_HI = (c == 0) ? IO_AW'('h3F7) : IO_AW'('h377);
    assign ch_hit[c] = in_win(io_addr, CMD_LO, CMD_HI) || in_win(io_addr, AUX_LO, AUX_HI);
  end

  assign intc_hit = in_win(io_addr, INTC_A_LO, INTC_A_HI) ||
                    in_win(io_addr, INTC_B_LO, INTC_B_HI);
  assign disk_hit = disk_sec ? ch_hit[1] : ch_hit[0];
  assign claim    = (intc_en && intc_hit) || (disk_en && disk_hit);

endmodule

// File: rtl/bpd_mem_decode.sv
module bpd_mem_decode #(
  parameter int MEM_AW     = 24,
  parameter int GRAN_SHIFT = 16,
  parameter int BND_W      = 9
) (
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              lo_bios_en,
  input  logic              hi_alias_en,
  input  logic [BND_W-1:0]  hole_bot,
  input  logic [BND_W-1:0]  hole_top,
  input  logic [BND_W-1:0]  tom,
  output logic              lo_hit,
  output logic              hi_hit,
  output logic              in_hole,
  output logic              above_tom,
  output logic              fwd
);

  localparam int ALIAS_SHIFT = 16;  // alias spans the top 64 KB
  localparam logic [MEM_AW-1:0] LO_BASE = MEM_AW'('h0E0000);
  localparam logic [MEM_AW-1:0] LO_LAST = MEM_AW'('h0FFFFF);

  function automatic logic page_in_hole(input logic [BND_W-1:0] p,
                                        input logic [BND_W-1:0] b,
                                        input logic [BND_W-1:0] t);
    return (t > b) && (p >= b) && (p < t);
  endfunction

  logic [BND_W-1:0] page;
  assign page = {1'b0, mem_addr[MEM_AW-1:GRAN_SHIFT]};

  assign lo_hit    = (mem_addr >= LO_BASE) && (mem_addr <= LO_LAST);
  assign hi_hit    = &mem_addr[MEM_AW-1:ALIAS_SHIFT];
  assign in_hole   = page_in_hole(page, hole_bot, hole_top);
  assign above_tom = (page >= tom);
  assign fwd       = (lo_bios_en && lo_hit) ||
                     (hi_alias_en && hi_hit && (in_hole || above_tom));

endmodule

// File: rtl/bridge_pos_decoder.sv
module bridge_pos_decoder
  import bpd_pkg::*;
#(
  parameter int IO_AW      = 16,
  parameter int MEM_AW     = 24,
  parameter int GRAN_SHIFT = 16,
  parameter int REG_DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_idx,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              io_req,
  input  logic [IO_AW-1:0]  io_addr,
  output logic              io_claim,
  output logic              io_fallback,
  input  logic              mem_req,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              mem_fwd,
  output logic              neg_mode
);

  localparam int BND_W = MEM_AW - GRAN_SHIFT + 1;

  dec_ctrl_t        ctrl_q;
  logic [BND_W-1:0] hole_bot_q, hole_top_q, tom_q;

  bpd_regs #(.REG_DW(REG_DW), .BND_W(BND_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .ctrl     (ctrl_q),
    .hole_bot (hole_bot_q),
    .hole_top (hole_top_q),
    .tom      (tom_q),
    .rdata    (reg_rdata)
  );

  // Named internal events, brought out for the checker
  logic intc_hit, disk_hit, io_pos;
  logic lo_hit, hi_hit, in_hole, above_tom, mem_pos;

  bpd_io_decode #(.IO_AW(IO_AW)) u_io (
    .io_addr  (io_addr),
    .intc_en  (ctrl_q.intc_en),
    .disk_en  (ctrl_q.disk_en),
    .disk_sec (ctrl_q.disk_sec),
    .intc_hit (intc_hit),
    .disk_hit (disk_hit),
    .claim    (io_pos)
  );

  bpd_mem_decode #(.MEM_AW(MEM_AW), .GRAN_SHIFT(GRAN_SHIFT), .BND_W(BND_W)) u_mem (
    .mem_addr    (mem_addr),
    .lo_bios_en  (ctrl_q.lo_bios_en),
    .hi_alias_en (ctrl_q.hi_alias_en),
    .hole_bot    (hole_bot_q),
    .hole_top    (hole_top_q),
    .tom         (tom_q),
    .lo_hit      (lo_hit),
    .hi_hit      (hi_hit),
    .in_hole     (in_hole),
    .above_tom   (above_tom),
    .fwd         (mem_pos)
  );

  assign io_claim    = io_req && io_pos;
  assign io_fallback = io_req && !io_pos;
  assign mem_fwd     = mem_req && mem_pos;
  assign neg_mode    = ctrl_q.neg_mode;

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
  parameter int BND_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_idx,
  input logic             io_req,
  input logic             io_claim,
  input logic             io_fallback,
  input logic             mem_req,
  input logic             mem_fwd,
  input logic             neg_mode,
  input logic [7:0]       ctrl_bits,
  input logic             lo_hit,
  input logic             in_hole,
  input logic             above_tom,
  input logic [BND_W-1:0] hole_bot,
  input logic [BND_W-1:0] hole_top
);

  a_r5_fallback_complement: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (io_claim != io_fallback));

  a_r11_io_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !io_req |-> (!io_claim && !io_fallback));

  a_r11_mem_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !mem_fwd);

  a_r5_claim_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (ctrl_bits[1] || ctrl_bits[2]));

  a_r9_empty_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_top <= hole_bot) |-> !in_hole);

  a_r8_alias_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fwd && !(lo_hit && ctrl_bits[4])) |-> (ctrl_bits[5] && (in_hole || above_tom)));

  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_bits[7:6] == 2'b00);

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_idx == 2'd0) |=> $stable(neg_mode));

  a_r6_mode_matches: assert property (@(posedge clk) disable iff (!rst_n)
    neg_mode == ctrl_bits[0]);

endmodule

bind bridge_pos_decoder bpd_checker #(.BND_W(BND_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_idx     (reg_idx),
  .io_req      (io_req),
  .io_claim    (io_claim),
  .io_fallback (io_fallback),
  .mem_req     (mem_req),
  .mem_fwd     (mem_fwd),
  .neg_mode    (neg_mode),
  .ctrl_bits   (ctrl_q),
  .lo_hit      (lo_hit),
  .in_hole     (in_hole),
  .above_tom   (above_tom),
  .hole_bot    (hole_bot_q),
  .hole_top    (hole_top_q)
);

// File: tb/bridge_pos_decoder_tb.sv
module bridge_pos_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        io_req = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_claim, io_fallback;
  logic        mem_req = 1'b0;
  logic [23:0] mem_addr = '0;
  logic        mem_fwd, neg_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // 50 MHz
  always #10 clk = ~clk;

  bridge_pos_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_req(io_req),
    .io_addr(io_addr), .io_claim(io_claim), .io_fallback(io_fallback),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_fwd(mem_fwd), .neg_mode(neg_mode)
  );

  localparam logic [15:0] IO_PROBE [27] = '{
    16'h01F, 16'h020, 16'h021, 16'h022, 16'h09F, 16'h0A0, 16'h0A1, 16'h0A2,
    16'h1020, 16'h10A0, 16'h16F, 16'h170, 16'h177, 16'h178, 16'h1EF, 16'h1F0,
    16'h1F7, 16'h1F8, 16'h375, 16'h376, 16'h377, 16'h378, 16'h3F5, 16'h3F6,
    16'h3F7, 16'h3F8, 16'h11F0};

  localparam logic [23:0] MEM_PROBE [10] = '{
    24'h0DFFFF, 24'h0E0000, 24'h0F1234, 24'h0FFFFF, 24'h100000,
    24'h7FFFFF, 24'hFEFFFF, 24'hFF0000, 24'hFF8000, 24'hFFFFFF};

  // Shadow of what was written, kept by the bench
  logic [7:0] s_ctrl;
  logic [8:0] s_bot, s_top, s_tom;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    case (idx)
      2'd0: s_ctrl = d[7:0] & 8'h3F;
      2'd1: s_bot = d[8:0];
      2'd2: s_top = d[8:0];
      default: s_tom = d[8:0];
    endcase
  endtask

  task automatic rd_check(input logic [1:0] idx, input logic [15:0] exp, input string tag);
    reg_idx = idx;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  function automatic bit exp_io(input logic [15:0] a, input logic [7:0] c);
    bit intc, pri, sec;
    intc = (a == 16'h020) || (a == 16'h021) || (a == 16'h0A0) || (a == 16'h0A1);
    pri  = (a inside {[16'h1F0:16'h1F7]}) || (a == 16'h3F6) || (a == 16'h3F7);
    sec  = (a inside {[16'h170:16'h177]}) || (a == 16'h376) || (a == 16'h377);
    return (c[1] && intc) || (c[2] && (c[3] ? sec : pri));
  endfunction

  function automatic bit exp_mem(input logic [23:0] a);
    bit lo, hi, hole, above;
    int pg;
    pg    = int'(a / 24'h10000);
    lo    = (a >= 24'h0E0000) && (a < 24'h100000);
    hi    = (a >= 24'hFF0000);
    hole  = (int'(s_top) > int'(s_bot)) && (pg >= int'(s_bot)) && (pg < int'(s_top));
    above = pg >= int'(s_tom);
    return (s_ctrl[4] && lo) || (s_ctrl[5] && hi && (hole || above));
  endfunction

  task automatic t_io_sweep(input logic [7:0] c, input string tag);
    wr(2'd0, {8'h00, c});
    io_req = 1'b1;
    for (int i = 0; i < 27; i++) begin
      bit e;
      io_addr = IO_PROBE[i];
      #1;
      e = exp_io(IO_PROBE[i], c);
      check(io_claim == e, tag, {io_addr, 15'd0, io_claim}, {io_addr, 15'd0, e});
      check(io_fallback == !e, "R5 fallback", {io_addr, 15'd0, io_fallback},
            {io_addr, 15'd0, !e});
    end
    io_req = 1'b0;
  endtask

  task automatic t_mem_sweep(input logic [7:0] c, input logic [8:0] b, input logic [8:0] t,
                             input logic [8:0] m, input string tag);
    wr(2'd0, {8'h00, c});
    wr(2'd1, {7'd0, b});
    wr(2'd2, {7'd0, t});
    wr(2'd3, {7'd0, m});
    mem_req = 1'b1;
    for (int i = 0; i < 10; i++) begin
      bit e;
      mem_addr = MEM_PROBE[i];
      #1;
      e = exp_mem(MEM_PROBE[i]);
      check(mem_fwd == e, tag, {mem_addr, 7'd0, mem_fwd}, {mem_addr, 7'd0, e});
    end
    mem_req = 1'b0;
  endtask

  task automatic t_reset;
    rd_check(2'd0, 16'h0, "R1 ctrl reset");
    rd_check(2'd1, 16'h0, "R1 hole bottom reset");
    rd_check(2'd2, 16'h0, "R1 hole top reset");
    rd_check(2'd3, 16'h0, "R1 top of memory reset");
    check(neg_mode == 1'b0, "R1 mode reset", neg_mode, 0);
    io_req = 1'b1; io_addr = 16'h020; #1;
    check(io_claim == 1'b0, "R1 no io claim", io_claim, 0);
    io_addr = 16'h1F0; #1;
    check(io_claim == 1'b0, "R1 no disk claim", io_claim, 0);
    io_req = 1'b0;
    mem_req = 1'b1; mem_addr = 24'h0E0000; #1;
    check(mem_fwd == 1'b0, "R1 no mem forward", mem_fwd, 0);
    mem_req = 1'b0;
  endtask

  task automatic t_regs;
    wr(2'd1, 16'h1ABC);
    rd_check(2'd1, 16'h00BC, "R10 R12 hole bottom width");
    wr(2'd2, 16'h0155);
    rd_check(2'd2, 16'h0155, "R12 hole top");
    wr(2'd3, 16'h0100);
    rd_check(2'd3, 16'h0100, "R12 top of memory");
    wr(2'd0, 16'hFFFF);
    rd_check(2'd0, 16'h003F, "R10 reserved ctrl bits");
    // Present data without the strobe: nothing may change
    @(negedge clk);
    reg_idx = 2'd3; reg_wdata = 16'h0077;
    @(negedge clk);
    rd_check(2'd3, 16'h0100, "R10 no write without strobe");
    rd_check(2'd0, 16'h003F, "R10 ctrl kept");
  endtask

  task automatic t_mode;
    wr(2'd0, 16'h0001); #1;
    check(neg_mode == 1'b1, "R6 negative mode", neg_mode, 1);
    wr(2'd0, 16'h0000); #1;
    check(neg_mode == 1'b0, "R6 subtractive mode", neg_mode, 0);
  endtask

  task automatic t_idle;
    wr(2'd0, 16'h003E);
    io_req = 1'b0; io_addr = 16'h020; #1;
    check(io_claim == 1'b0, "R11 io idle claim", io_claim, 0);
    check(io_fallback == 1'b0, "R11 io idle fallback", io_fallback, 0);
    mem_req = 1'b0; mem_addr = 24'h0E0000; #1;
    check(mem_fwd == 1'b0, "R11 mem idle", mem_fwd, 0);
  endtask

  initial begin
    s_ctrl = '0; s_bot = '0; s_top = '0; s_tom = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mode();
    t_io_sweep(8'h00, "R5 both groups off");
    t_io_sweep(8'h02, "R2 interrupt group");
    t_io_sweep(8'h04, "R3 primary disk");
    t_io_sweep(8'h0C, "R4 secondary disk");
    t_io_sweep(8'h08, "R5 select without enable");
    t_io_sweep(8'h06, "R2 R3 both groups");
    t_idle();
    t_mem_sweep(8'h10, 9'h000, 9'h000, 9'h100, "R7 low BIOS");
    t_mem_sweep(8'h00, 9'h000, 9'h000, 9'h000, "R7 R8 enables off");
    t_mem_sweep(8'h20, 9'h000, 9'h000, 9'h100, "R8 alias below top, no hole");
    t_mem_sweep(8'h20, 9'h0F0, 9'h100, 9'h100, "R8 alias inside hole");
    t_mem_sweep(8'h20, 9'h000, 9'h000, 9'h0FF, "R8 alias at top of memory");
    t_mem_sweep(8'h30, 9'h000, 9'h000, 9'h080, "R7 R8 both regions");
    t_mem_sweep(8'h20, 9'h100, 9'h080, 9'h100, "R9 inverted hole");
    t_mem_sweep(8'h20, 9'h0FF, 9'h0FF, 9'h100, "R9 zero size hole");
    t_mem_sweep(8'h20, 9'h0FE, 9'h0FF, 9'h100, "R9 hole top exclusive");
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule